// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a programmable logic device. It receives a sum-of-products term from the logic array ahead of it, together with static configuration bits. It produces a pin-side data value with an output-enable flag, and a feedback bit that returns to the array. The configuration selects one of three behaviours: a plain combinatorial path, a transparent latch, or an edge-triggered register. The register can act as a D or a T element. The cell also selects output polarity and picks one of several clock sources.

All state changes on the single fabric clock `clk`. The clock sources of the cell arrive on `clk_src` and are sampled on that clock. The register sees a rising edge of the selected source when the source is sampled high and was sampled low at the previous `clk` edge. The latch is transparent while the selected source is high. Reset is synchronous. Configuration may change only while reset is held, except for polarity, which sits after the storage element and may change at any time. A buried variant, chosen by a parameter, keeps the feedback path but never drives its pin.

Top module: `pld_out_cell`

## Requirements
- R1: With `cfg_mode` = 2'b00 (combinatorial), `fb` equals `sop` in the same cycle, and the stored bit is left unchanged.
- R2: With `cfg_mode` = 2'b01 (latch), `fb` follows `sop` while the selected source is high, and the stored bit takes `sop` at each `clk` edge where the source is high. While the source is low, `fb` shows the stored bit.
- R3: With `cfg_mode[1]` = 1 and `cfg_tff` = 0, a `clk` edge at which the selected source is sampled 1 after a 0 at the previous edge loads `sop` into the stored bit. `fb` shows the stored bit from that edge on.
- R4: With `cfg_mode[1]` = 1 and `cfg_tff` = 1, such an edge inverts the stored bit when `sop` = 1 and keeps it when `sop` = 0.
- R5: In registered mode, a `clk` edge that is not a rising edge of the selected source leaves the stored bit unchanged, whether the source stays high or stays low.
- R6: `cfg_clksel` is the index into `clk_src` of the source in use. Activity on the other bits of `clk_src` has no effect.
- R7: On a driving cell, `pin_d` = `fb` XOR `cfg_inv` in every cycle. `cfg_inv` never alters the stored bit.
- R8: While `rst` = 1 at a `clk` edge, the stored bit is cleared to 0. The source history keeps tracking during reset, so a source held high across the release of reset gives no edge.
- R9: `cfg_mode` = 2'b11 behaves exactly like 2'b10 (registered).
- R10: On a driving cell, `pin_oe` equals `oe_in`. `pin_d` carries the data value whether the enable is high or low.
- R11: With `BURIED` = 1, `pin_oe` and `pin_d` are always 0, and `fb` behaves as on a driving cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00 combinatorial, 01 latch, 1x registered |
| cfg_tff | input | 1 | Registered element acts as T when 1, D when 0 |
| cfg_inv | input | 1 | Invert the pin data |
| cfg_clksel | input | $clog2(NCLK) | Index of the clock source in use |
| clk_src | input | NCLK | Candidate clock sources, sampled on clk |
| sop | input | 1 | Sum-of-products term from the array |
| oe_in | input | 1 | Output enable for the pin |
| pin_oe | output | 1 | Pin enable flag |
| pin_d | output | 1 | Pin data after polarity |
| fb | output | 1 | Feedback to the array, before polarity |

## Verification
The hardest case to reach from the ports is the boundary between reset and the first source edge. A source that is already high when reset releases must not count as an edge, while a source that rises in the first cycle after reset must. The stimulus holds selected and unselected sources at chosen levels through each reset and releases reset in both states. It then mixes steady-high, steady-low and toggling sources, so that hold cycles and toggle cycles appear next to each other in T mode.

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter int NCLK   = 4,
  parameter bit BURIED = 1'b0,
  localparam int SW    = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_tff,
  input  logic            cfg_inv,
  input  logic [SW-1:0]   cfg_clksel,
  input  logic [NCLK-1:0] clk_src,
  input  logic            sop,
  input  logic            oe_in,
  output logic            pin_oe,
  output logic            pin_d,
  output logic            fb
);

  logic sel, sel_q, store, val;
  logic is_comb, is_lat, is_reg;

  assign sel     = clk_src[cfg_clksel];
  assign is_comb = (cfg_mode == 2'b00);
  assign is_lat  = (cfg_mode == 2'b01);
  assign is_reg  = cfg_mode[1];

  always_ff @(posedge clk) begin
    sel_q <= sel;
    if (rst)
      store <= 1'b0;
    else if (is_lat) begin
      if (sel) store <= sop;
    end else if (is_reg && sel && !sel_q)
      store <= cfg_tff ? (store ^ sop) : sop;
  end

  always_comb begin
    if (is_comb)            val = sop;
    else if (is_lat && sel) val = sop;
    else                    val = store;
  end

  assign fb = val;

  generate
    if (BURIED) begin : g_buried
      assign pin_oe = 1'b0;
      assign pin_d  = 1'b0;
    end else begin : g_drive
      assign pin_oe = oe_in;
      assign pin_d  = val ^ cfg_inv;
    end
  endgenerate

endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int NCLK   = 4,
  parameter bit BURIED = 1'b0,
  localparam int SW    = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      cfg_mode,
  input logic            cfg_tff,
  input logic            cfg_inv,
  input logic [SW-1:0]   cfg_clksel,
  input logic [NCLK-1:0] clk_src,
  input logic            sop,
  input logic            oe_in,
  input logic            pin_oe,
  input logic            pin_d,
  input logic            fb
);
  logic s;
  assign s = clk_src[cfg_clksel];

  AST_COMB_PASS: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b00) |-> (fb == sop));  // R1

  AST_LAT_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'b01 && s) |-> (fb == sop));  // R2

  AST_D_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode[1] && !cfg_tff && s && !$past(s)) |=> (fb == $past(sop)));  // R3

  AST_T_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode[1] && cfg_tff && s && !$past(s)) |=> (fb == ($past(fb) ^ $past(sop))));  // R4

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode[1] && !(s && !$past(s))) |=> $stable(fb));  // R5

  AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
    !BURIED |-> (pin_d == (fb ^ cfg_inv)));  // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cfg_mode[1]) |-> (fb == 1'b0));  // R8

  AST_OE_PASS: assert property (@(posedge clk) disable iff (rst)
    !BURIED |-> (pin_oe == oe_in));  // R10

  AST_BURIED_QUIET: assert property (@(posedge clk) disable iff (rst)
    BURIED |-> (!pin_oe && !pin_d));  // R11
endmodule

bind pld_out_cell pld_out_cell_chk #(.NCLK(NCLK), .BURIED(BURIED)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff), .cfg_inv(cfg_inv),
  .cfg_clksel(cfg_clksel), .clk_src(clk_src), .sop(sop), .oe_in(oe_in),
  .pin_oe(pin_oe), .pin_d(pin_d), .fb(fb)
);

// File: tb/tb_pld_out_cell.sv
module tb_pld_out_cell;
  localparam int NCLK = 4;
  localparam int SW   = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1;
  logic [1:0]      cfg_mode = 2'b00;
  logic            cfg_tff = 1'b0, cfg_inv = 1'b0;
  logic [SW-1:0]   cfg_clksel = '0;
  logic [NCLK-1:0] clk_src = '0;
  logic            sop = 1'b0, oe_in = 1'b0;
  logic pin_oe, pin_d, fb, b_oe, b_d, b_fb;

  pld_out_cell #(.NCLK(NCLK), .BURIED(1'b0)) dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff), .cfg_inv(cfg_inv),
    .cfg_clksel(cfg_clksel), .clk_src(clk_src), .sop(sop), .oe_in(oe_in),
    .pin_oe(pin_oe), .pin_d(pin_d), .fb(fb));

  pld_out_cell #(.NCLK(NCLK), .BURIED(1'b1)) dut_bur (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff), .cfg_inv(cfg_inv),
    .cfg_clksel(cfg_clksel), .clk_src(clk_src), .sop(sop), .oe_in(oe_in),
    .pin_oe(b_oe), .pin_d(b_d), .fb(b_fb));

  int n_cmp = 0, n_bad = 0;
  bit m_store = 1'b0, m_prev = 1'b0;
  string phase = "R8";

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
    end
  endtask

  function automatic string mode_tag();
    if (cfg_mode == 2'b00) return "R1";
    if (cfg_mode == 2'b01) return "R2";
    return cfg_tff ? "R4" : "R3";
  endfunction

  task automatic cycle(input logic r, input logic [NCLK-1:0] src, input logic s, input logic oe, input logic inv);
    bit sl, v;
    @(negedge clk);
    rst = r; clk_src = src; sop = s; oe_in = oe; cfg_inv = inv;
    #1;
    sl = src[cfg_clksel];
    if (cfg_mode == 2'b00)      v = s;
    else if (cfg_mode == 2'b01) v = sl ? s : m_store;
    else                        v = m_store;
    if (!r) begin
      chk(mode_tag(), fb, v);
      chk("R7", pin_d, v ^ inv);
      chk("R10", pin_oe, oe);
      chk("R11", b_fb, v);
      chk("R11", b_oe, 1'b0);
      chk("R11", b_d, 1'b0);
    end
    @(posedge clk);
    if (r) m_store = 1'b0;
    else if (cfg_mode == 2'b01) begin
      if (sl) m_store = s;
    end else if (cfg_mode[1] && sl && !m_prev)
      m_store = cfg_tff ? (m_store ^ s) : s;
    m_prev = sl;
  endtask

  task automatic configure(input logic [1:0] md, input logic t, input logic [SW-1:0] cs, input logic [NCLK-1:0] src);
    @(negedge clk);
    rst = 1'b1; cfg_mode = md; cfg_tff = t; cfg_clksel = cs;
    cycle(1'b1, src, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, src, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic rand_run(input int n, input bit own_toggle_only);
    for (int i = 0; i < n; i++) begin
      logic [NCLK-1:0] src;
      src = NCLK'($urandom);
      if (own_toggle_only) src[cfg_clksel] = 1'(i / 2);
      cycle(1'b0, src, 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state with registered mode, first check after release
    configure(2'b10, 1'b0, 2'd0, 4'b0000);
    phase = "R8";
    cycle(1'b0, 4'b0000, 1'b1, 1'b1, 1'b0);
    chk("R8", fb, 1'b0);
    // R1 / R7: combinatorial with random polarity
    phase = "R1";
    configure(2'b00, 1'b0, 2'd1, 4'b0000);
    rand_run(60, 1'b0);
    // R2: latch, several selects
    phase = "R2";
    for (int c = 0; c < NCLK; c++) begin
      configure(2'b01, 1'b0, SW'(c), 4'b0000);
      rand_run(50, 1'b0);
    end
    // R3 / R6: D register, unselected sources random
    phase = "R6";
    for (int c = 0; c < NCLK; c++) begin
      configure(2'b10, 1'b0, SW'(c), 4'b0000);
      rand_run(60, 1'b0);
      rand_run(40, 1'b1);
    end
    // R5: steady high and steady low selected source
    phase = "R5";
    configure(2'b10, 1'b0, 2'd2, 4'b0000);
    cycle(1'b0, 4'b0100, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b0, 4'b0100, 1'($urandom), 1'b1, 1'b0);
    chk("R5", fb, 1'b1);
    for (int i = 0; i < 6; i++) cycle(1'b0, 4'b1011, 1'($urandom), 1'b1, 1'b0);
    chk("R5", fb, 1'b1);
    // R4: T register
    phase = "R4";
    for (int c = 0; c < NCLK; c++) begin
      configure(2'b10, 1'b1, SW'(c), 4'b0000);
      rand_run(80, 1'b1);
      rand_run(40, 1'b0);
    end
    // R9: mode 11 as registered, D then T
    phase = "R9";
    configure(2'b11, 1'b0, 2'd3, 4'b0000);
    rand_run(60, 1'b1);
    configure(2'b11, 1'b1, 2'd1, 4'b0000);
    rand_run(60, 1'b1);
    // R8: release reset with selected source high: no edge
    phase = "R8";
    configure(2'b10, 1'b0, 2'd0, 4'b0001);
    cycle(1'b0, 4'b0001, 1'b1, 1'b1, 1'b0);
    cycle(1'b0, 4'b0001, 1'b1, 1'b1, 1'b0);
    chk("R8", fb, 1'b0);
    // R8: release reset low, rise in first cycle
    configure(2'b10, 1'b0, 2'd0, 4'b0000);
    cycle(1'b0, 4'b0001, 1'b1, 1'b0, 1'b1);
    cycle(1'b0, 4'b0001, 1'b0, 1'b0, 1'b1);
    chk("R8", fb, 1'b1);
    // mid-run reset on T cell
    configure(2'b10, 1'b1, 2'd2, 4'b0000);
    rand_run(30, 1'b1);
    cycle(1'b1, 4'b0100, 1'b1, 1'b0, 1'b0);
    rand_run(30, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule